// File: doc/BRIEF.md
# Late-Write Burst Synchronous SRAM

This block is a synthesizable model of a small synchronous static RAM. Reads and writes can follow each other on consecutive clock edges without idle cycles. A command is captured on a rising clock edge. For a write, the data word arrives one or two enabled edges later, so the data bus never has to turn around. A mode pin picks the read latency. In pipelined mode the read data passes through an output register. In flow-through mode the read data comes straight from the array.

Each access is either a single word or a four-beat burst. A load command names the start address. Each later advance command moves to the next beat. The low two address bits follow a linear or an interleaved order, and after four beats they return to the start value. Words are 18 bits wide and made of two 9-bit byte lanes, which can be written separately. A compare-and-bypass path serves a read whose address still has a late write pending.

There are three chip selects for depth expansion. An active-low clock enable freezes the whole block. An asynchronous output enable can blank the data outputs at any time. The block has no internal tri-state: the output-valid flag `dataOutEn` tells the pad logic when to drive.

Top module: `lw_sram`

## Requirements
- R1: After reset `dataOutEn` is 0 and `dataOut` is 0. No burst is open, so an advance command issued before any load produces no output.
- R2: In pipelined mode (`flowThru`=0), a read command captured at edge n presents its word from edge n+1 until edge n+2, with `dataOutEn`=1 for that cycle only.
- R3: In flow-through mode (`flowThru`=1), a read command captured at edge n presents its word from edge n until edge n+1.
- R4: Write data is sampled from `dataIn` at edge n+2 after a write command at edge n in pipelined mode, and at edge n+1 in flow-through mode.
- R5: Reads and writes may alternate on every edge with no deselect cycle between them. Every read returns the correct word, and a read output window never coincides with the write-data cycle.
- R6: A pipelined read whose address has a late write still pending returns the newly written lanes merged with the old content of the lanes that are not written.
- R7: While `clkEnN`=1 every register holds, including the output data and its valid flag, and all other synchronous inputs are ignored.
- R8: With `advance`=1 and an open burst, the block issues the next beat with the same operation as the load. The fifth beat returns to the start address. Address bits above bit 1 never change inside a burst.
- R9: With `orderSel`=0 the low two address bits on beat k (k = 0..3) are (start + k) mod 4.
- R10: With `orderSel`=1 the low two address bits on beat k are start XOR k.
- R11: Active-low `byteWeN[i]`=0 writes bits [9i+8:9i]. With both bits at 1, the write leaves the word unchanged.
- R12: A new access starts only when `selAN`=0, `selB`=1 and `selCN`=0. Any other combination is a deselect: nothing is accessed and the open burst ends, so a following advance has no effect.
- R13: `oeN`=1 forces `dataOutEn` and `dataOut` to 0 at once, without waiting for a clock edge. Setting `oeN` back to 0 brings back the held read word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous active-low reset of control state |
| clkEnN | input | 1 | Active-low clock enable; high freezes the block |
| selAN | input | 1 | Chip select, active low |
| selB | input | 1 | Chip select, active high |
| selCN | input | 1 | Chip select, active low |
| weN | input | 1 | Active-low write on a load command |
| advance | input | 1 | 1 continues the open burst, 0 loads a new address |
| byteWeN | input | 2 | Active-low byte-lane write enables |
| addr | input | 6 | Word address for load commands |
| dataIn | input | 18 | Late write data |
| oeN | input | 1 | Asynchronous active-low output enable |
| orderSel | input | 1 | Burst order: 0 linear, 1 interleaved |
| flowThru | input | 1 | Read mode: 1 flow-through, 0 pipelined |
| dataOut | output | 18 | Read data, 0 when not driven |
| dataOutEn | output | 1 | Read data valid and enabled for driving |

## Verification
The bench targets the points where late-write timing can go wrong:
- A pipelined read issued directly after a write to the same address, including a partial-lane write. A design without the bypass returns the stale word.
- Alternating reads and writes on every edge. A design that samples write data on the wrong edge stores the neighbouring bus value.
- The fifth burst beat in both orders. Without the wrap, the burst would step onto the next four-word group.
- A stall held while read data is valid, with a write command driven during the stall. A design that ignores the clock enable either drops the data or performs that write.
- Deselects by each chip select in turn, each followed by an advance. A design that lets a deselect leave the burst open issues an extra access.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

  // Strobes sent from the command decoder to the storage datapath.
  typedef struct packed {
    logic step;     // edge is enabled (clock enable asserted)
    logic take;     // an access is issued on this edge
    logic isWrite;  // the issued access is a write
  } strobe_t;

endpackage

// File: rtl/lw_sram_burst.sv
module lw_sram_burst (
  input  logic       orderSel,
  input  logic [1:0] startLow,
  input  logic [1:0] beat,
  output logic [1:0] lowBits
);

  // Linear order counts up from the start; interleaved order flips bits.
  always_comb begin
    if (orderSel) lowBits = startLow ^ beat;
    else          lowBits = startLow + beat;
  end

endmodule

// File: rtl/lw_sram_ctrl.sv
module lw_sram_ctrl
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              selAN,
  input  logic              selB,
  input  logic              selCN,
  input  logic              weN,
  input  logic              advance,
  input  logic              orderSel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  byteWeN,
  output strobe_t           strobes,
  output logic [ADDR_W-1:0] accAddr,
  output logic [LANES-1:0]  accLanes
);

  logic              selected;
  logic              loadCmd;
  logic              contCmd;
  logic              burstActive;
  logic              burstWrite;
  logic [ADDR_W-1:0] baseAddr;
  logic [1:0]        beat;
  logic [1:0]        nextBeat;
  logic [1:0]        seqLow;

  assign selected = !selAN && selB && !selCN;
  assign loadCmd  = selected && !advance;
  assign contCmd  = selected && advance && burstActive;
  assign nextBeat = beat + 2'd1;

  lw_sram_burst u_burst (
    .orderSel (orderSel),
    .startLow (baseAddr[1:0]),
    .beat     (nextBeat),
    .lowBits  (seqLow)
  );

  always_comb begin
    strobes.step    = !clkEnN;
    strobes.take    = loadCmd || contCmd;
    strobes.isWrite = loadCmd ? !weN : burstWrite;
    accAddr         = loadCmd ? addr : {baseAddr[ADDR_W-1:2], seqLow};
    accLanes        = ~byteWeN;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      burstActive <= 1'b0;
      burstWrite  <= 1'b0;
      baseAddr    <= '0;
      beat        <= '0;
    end else if (!clkEnN) begin
      if (loadCmd) begin
        burstActive <= 1'b1;
        burstWrite  <= !weN;
        baseAddr    <= addr;
        beat        <= '0;
      end else if (contCmd) begin
        beat <= nextBeat;
      end else if (!selected) begin
        burstActive <= 1'b0;
      end
    end
  end

  // R12: a deselect on an enabled edge closes the burst
  a_r12_deselect_ends_burst: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && !selected) |=> !burstActive);

  // R8: the fifth beat returns to the start address
  a_r8_wrap_to_start: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && contCmd && beat == 2'd3) |-> (accAddr == baseAddr));

endmodule

// File: rtl/lw_sram_dp.sv
module lw_sram_dp
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [LANES-1:0]  accLanes,
  input  logic              flowThru,
  input  logic              oeN,
  input  logic [LANES*LANE_W-1:0] dataIn,
  output logic [LANES*LANE_W-1:0] dataOut,
  output logic              dataOutEn
);

  localparam int WORD_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  // Read pipeline
  logic              rdV1, rdV2;
  logic [ADDR_W-1:0] rdA1;
  logic [WORD_W-1:0] pipeData;

  // Late-write pipeline: stage 1 after the command, stage 2 one edge later
  logic              wV1, wV2;
  logic [ADDR_W-1:0] wA1, wA2;
  logic [LANES-1:0]  wL1, wL2;

  // Stage whose data is taken on the current edge
  logic              dsV;
  logic [ADDR_W-1:0] dsA;
  logic [LANES-1:0]  dsL;
  logic [WORD_W-1:0] dsOld;
  logic [WORD_W-1:0] mergedWord;
  logic [WORD_W-1:0] rdRaw;
  logic [WORD_W-1:0] pipeNext;
  logic              bypassHit;
  logic              validOut;
  logic [WORD_W-1:0] outWord;

  assign dsV   = flowThru ? wV1 : wV2;
  assign dsA   = flowThru ? wA1 : wA2;
  assign dsL   = flowThru ? wL1 : wL2;
  assign dsOld = mem[dsA];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign mergedWord[i*LANE_W +: LANE_W] =
      dsL[i] ? dataIn[i*LANE_W +: LANE_W] : dsOld[i*LANE_W +: LANE_W];
  end

  assign rdRaw     = mem[rdA1];
  assign bypassHit = dsV && (dsA == rdA1);
  assign pipeNext  = bypassHit ? mergedWord : rdRaw;

  always_ff @(posedge clk) begin
    if (strobes.step && dsV) mem[dsA] <= mergedWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdV1     <= 1'b0;
      rdV2     <= 1'b0;
      rdA1     <= '0;
      pipeData <= '0;
      wV1      <= 1'b0;
      wV2      <= 1'b0;
      wA1      <= '0;
      wA2      <= '0;
      wL1      <= '0;
      wL2      <= '0;
    end else if (strobes.step) begin
      rdV1     <= strobes.take && !strobes.isWrite;
      rdA1     <= accAddr;
      rdV2     <= rdV1;
      pipeData <= pipeNext;
      wV1      <= strobes.take && strobes.isWrite;
      wA1      <= accAddr;
      wL1      <= accLanes;
      wV2      <= wV1;
      wA2      <= wA1;
      wL2      <= wL1;
    end
  end

  assign validOut  = flowThru ? rdV1 : rdV2;
  assign outWord   = flowThru ? rdRaw : pipeData;
  assign dataOutEn = validOut && !oeN;
  assign dataOut   = dataOutEn ? outWord : '0;

  // R7: a disabled edge changes nothing on the read side
  a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.step |=> ($stable(pipeData) && $stable(rdV1) && $stable(rdV2)));

  // R5: read output window and write-data cycle never coincide
  a_r5_no_bus_clash: assert property (@(posedge clk) disable iff (!rstN)
    !(validOut && dsV));

  // R2: pipelined read reaches the output register one enabled edge later
  a_r2_pipe_latency: assert property (@(posedge clk) disable iff (!rstN)
    (!flowThru && strobes.step && rdV1) |=> rdV2);

endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    clkEnN,
  input  logic                    selAN,
  input  logic                    selB,
  input  logic                    selCN,
  input  logic                    weN,
  input  logic                    advance,
  input  logic [LANES-1:0]        byteWeN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] dataIn,
  input  logic                    oeN,
  input  logic                    orderSel,
  input  logic                    flowThru,
  output logic [LANES*LANE_W-1:0] dataOut,
  output logic                    dataOutEn
);

  strobe_t           strobes;
  logic [ADDR_W-1:0] accAddr;
  logic [LANES-1:0]  accLanes;

  lw_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .clkEnN   (clkEnN),
    .selAN    (selAN),
    .selB     (selB),
    .selCN    (selCN),
    .weN      (weN),
    .advance  (advance),
    .orderSel (orderSel),
    .addr     (addr),
    .byteWeN  (byteWeN),
    .strobes  (strobes),
    .accAddr  (accAddr),
    .accLanes (accLanes)
  );

  lw_sram_dp #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .accAddr   (accAddr),
    .accLanes  (accLanes),
    .flowThru  (flowThru),
    .oeN       (oeN),
    .dataIn    (dataIn),
    .dataOut   (dataOut),
    .dataOutEn (dataOutEn)
  );

  // R13: output enable high blanks the outputs
  a_r13_oe_blanks: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> (!dataOutEn && dataOut == '0));

endmodule

// File: tb/lw_sram_test.sv
module lw_sram_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clkEnN = 1'b0;
  logic        selAN = 1'b0;
  logic        selB = 1'b0;
  logic        selCN = 1'b0;
  logic        weN = 1'b1;
  logic        advance = 1'b0;
  logic [1:0]  byteWeN = 2'b11;
  logic [5:0]  addr = '0;
  logic [17:0] dataIn = '0;
  logic        oeN = 1'b0;
  logic        orderSel = 1'b0;
  logic        flowThru = 1'b0;
  logic [17:0] dataOut;
  logic        dataOutEn;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lw_sram uut (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .selAN(selAN), .selB(selB),
    .selCN(selCN), .weN(weN), .advance(advance), .byteWeN(byteWeN),
    .addr(addr), .dataIn(dataIn), .oeN(oeN), .orderSel(orderSel),
    .flowThru(flowThru), .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

  function automatic logic [17:0] valOf(input logic [5:0] a);
    return {a, 3'b101, a, 3'b010};
  endfunction

  task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkData(input string tag, input logic [17:0] exp);
    check({tag, " en"}, {17'b0, dataOutEn}, 18'd1);
    check({tag, " data"}, dataOut, exp);
  endtask

  task automatic checkOff(input string tag);
    check({tag, " en"}, {17'b0, dataOutEn}, 18'd0);
  endtask

  // desel: 0 selected, 1 selAN high, 2 selB low, 3 selCN high
  task automatic drive(input int desel, input logic isW, input logic adv,
                       input logic [5:0] a, input logic [1:0] bwN, input logic [17:0] din);
    selAN   = (desel == 1);
    selB    = (desel != 2);
    selCN   = (desel == 3);
    weN     = !isW;
    advance = adv;
    addr    = a;
    byteWeN = bwN;
    dataIn  = din;
    @(negedge clk);
  endtask

  task automatic idle(input logic [17:0] din);
    drive(2, 1'b0, 1'b0, 6'd0, 2'b11, din);
  endtask

  task automatic wr(input logic [5:0] a, input logic [17:0] d, input logic [1:0] bwN);
    drive(0, 1'b1, 1'b0, a, bwN, 18'd0);
    if (!flowThru) idle(18'd0);
    idle(d);
    idle(18'd0);
  endtask

  task automatic rdchk(input logic [5:0] a, input logic [17:0] exp, input string tag);
    drive(0, 1'b0, 1'b0, a, 2'b11, 18'd0);
    if (!flowThru) idle(18'd0);
    checkData(tag, exp);
    idle(18'd0);
  endtask

  task automatic t_reset;
    checkOff("R1 reset");
    check("R1 reset data", dataOut, 18'd0);
    drive(0, 1'b0, 1'b1, 6'd3, 2'b11, 18'd0);
    idle(18'd0);
    checkOff("R1 advance without load");
    idle(18'd0);
    checkOff("R1 advance without load later");
  endtask

  task automatic prefill;
    flowThru = 1'b1;
    for (int a = 0; a < 64; a++) wr(6'(a), valOf(6'(a)), 2'b00);
  endtask

  task automatic t_flow_basic;
    flowThru = 1'b1;
    wr(6'd7, 18'h2C3A1, 2'b00);
    rdchk(6'd7, 18'h2C3A1, "R3 R4 flow write then read");
  endtask

  task automatic t_pipe_basic;
    flowThru = 1'b0;
    wr(6'd5, 18'h1B0F0, 2'b00);
    drive(0, 1'b0, 1'b0, 6'd5, 2'b11, 18'd0);
    checkOff("R2 pipe not yet");
    idle(18'd0);
    checkData("R2 R4 pipe read", 18'h1B0F0);
    idle(18'd0);
    checkOff("R2 pipe single cycle");
  endtask

  task automatic t_pipe_alternate;
    flowThru = 1'b0;
    drive(0, 1'b0, 1'b0, 6'd10, 2'b11, 18'd0);      // e0 read 10
    checkOff("R5 pipe e0");
    drive(0, 1'b1, 1'b0, 6'd11, 2'b00, 18'd0);      // e1 write 11
    checkData("R5 pipe read 10", valOf(6'd10));
    drive(0, 1'b0, 1'b0, 6'd11, 2'b11, 18'd0);      // e2 read 11
    checkOff("R5 pipe e2");
    drive(0, 1'b1, 1'b0, 6'd10, 2'b00, 18'h0C0DE);  // e3 write 10, data of e1
    checkData("R6 R5 pipe read 11 bypass", 18'h0C0DE);
    drive(0, 1'b0, 1'b0, 6'd10, 2'b11, 18'd0);      // e4 read 10
    checkOff("R5 pipe e4");
    idle(18'h3D00D);                                // e5 data of e3
    checkData("R6 R5 pipe read 10 bypass", 18'h3D00D);
    idle(18'd0);
    checkOff("R5 pipe end");
    rdchk(6'd11, 18'h0C0DE, "R4 pipe stored 11");
  endtask

  task automatic t_flow_alternate;
    flowThru = 1'b1;
    drive(0, 1'b1, 1'b0, 6'd20, 2'b00, 18'd0);
    checkOff("R5 flow e0");
    drive(0, 1'b0, 1'b0, 6'd20, 2'b11, 18'h15A5A);
    checkData("R5 R4 flow read 20", 18'h15A5A);
    drive(0, 1'b1, 1'b0, 6'd21, 2'b00, 18'd0);
    checkOff("R5 flow e2");
    drive(0, 1'b0, 1'b0, 6'd21, 2'b11, 18'h2A5A5);
    checkData("R5 R4 flow read 21", 18'h2A5A5);
    idle(18'd0);
    checkOff("R5 flow end");
  endtask

  task automatic t_burst_linear;
    flowThru = 1'b0;
    orderSel = 1'b0;
    drive(0, 1'b0, 1'b0, 6'd34, 2'b11, 18'd0);
    drive(0, 1'b0, 1'b1, 6'd0, 2'b11, 18'd0);
    checkData("R9 linear beat0", valOf(6'd34));
    drive(0, 1'b0, 1'b1, 6'd0, 2'b11, 18'd0);
    checkData("R9 linear beat1", valOf(6'd35));
    drive(0, 1'b0, 1'b1, 6'd0, 2'b11, 18'd0);
    checkData("R9 linear beat2", valOf(6'd32));
    drive(0, 1'b0, 1'b1, 6'd0, 2'b11, 18'd0);
    checkData("R9 linear beat3", valOf(6'd33));
    idle(18'd0);
    checkData("R8 linear wrap", valOf(6'd34));
    idle(18'd0);
    checkOff("R8 linear end");
  endtask

  task automatic t_burst_interleave;
    flowThru = 1'b1;
    orderSel = 1'b1;
    drive(0, 1'b0, 1'b0, 6'd41, 2'b11, 18'd0);
    checkData("R10 interleave beat0", valOf(6'd41));
    drive(0, 1'b0, 1'b1, 6'd0, 2'b11, 18'd0);
    checkData("R10 interleave beat1", valOf(6'd40));
    drive(0, 1'b0, 1'b1, 6'd0, 2'b11, 18'd0);
    checkData("R10 interleave beat2", valOf(6'd43));
    drive(0, 1'b0, 1'b1, 6'd0, 2'b11, 18'd0);
    checkData("R10 interleave beat3", valOf(6'd42));
    drive(0, 1'b0, 1'b1, 6'd0, 2'b11, 18'd0);
    checkData("R8 interleave wrap", valOf(6'd41));
    idle(18'd0);
    checkOff("R8 interleave end");
    orderSel = 1'b0;
  endtask

  task automatic t_burst_write;
    flowThru = 1'b0;
    orderSel = 1'b0;
    drive(0, 1'b1, 1'b0, 6'd49, 2'b00, 18'd0);
    drive(0, 1'b0, 1'b1, 6'd0, 2'b00, 18'd0);
    drive(0, 1'b0, 1'b1, 6'd0, 2'b00, 18'h15000);
    drive(0, 1'b0, 1'b1, 6'd0, 2'b00, 18'h15001);
    idle(18'h15002);
    idle(18'h15003);
    idle(18'd0);
    rdchk(6'd49, 18'h15000, "R8 burst write beat0");
    rdchk(6'd50, 18'h15001, "R8 burst write beat1");
    rdchk(6'd51, 18'h15002, "R8 burst write beat2");
    rdchk(6'd48, 18'h15003, "R8 burst write beat3");
    rdchk(6'd52, valOf(6'd52), "R8 burst stays in group");
  endtask

  task automatic t_lanes;
    flowThru = 1'b1;
    wr(6'd60, 18'h3FFFF, 2'b00);
    wr(6'd60, 18'h2AB55, 2'b10);
    rdchk(6'd60, 18'h3FF55, "R11 lane0 only");
    wr(6'd60, 18'h00000, 2'b01);
    rdchk(6'd60, 18'h00155, "R11 lane1 only");
    wr(6'd60, 18'h3FFFF, 2'b11);
    rdchk(6'd60, 18'h00155, "R11 no lanes no-op");
  endtask

  task automatic t_bypass_merge;
    flowThru = 1'b0;
    drive(0, 1'b1, 1'b0, 6'd12, 2'b01, 18'd0);
    drive(0, 1'b0, 1'b0, 6'd12, 2'b11, 18'd0);
    idle(18'h2E6C9);
    checkData("R6 merged bypass", {9'h173, valOf(6'd12)[8:0]});
    idle(18'd0);
  endtask

  task automatic t_stall;
    flowThru = 1'b0;
    drive(0, 1'b0, 1'b0, 6'd33, 2'b11, 18'd0);
    idle(18'd0);
    checkData("R7 before stall", valOf(6'd33));
    clkEnN = 1'b1;
    drive(0, 1'b1, 1'b0, 6'd33, 2'b00, 18'h3ABCD);
    checkData("R7 stall 1", valOf(6'd33));
    drive(0, 1'b1, 1'b0, 6'd33, 2'b00, 18'h3ABCD);
    checkData("R7 stall 2", valOf(6'd33));
    clkEnN = 1'b0;
    idle(18'h3ABCD);
    checkOff("R7 after stall");
    idle(18'h3ABCD);
    idle(18'd0);
    rdchk(6'd33, valOf(6'd33), "R7 stalled write ignored");
  endtask

  task automatic t_deselect;
    flowThru = 1'b0;
    for (int k = 1; k <= 3; k++) begin
      drive(k, 1'b1, 1'b0, 6'd62, 2'b00, 18'd0);
      idle(18'd0);
      idle(18'h01234);
      idle(18'd0);
      rdchk(6'd62, valOf(6'd62), "R12 deselected write");
    end
    drive(0, 1'b0, 1'b0, 6'd40, 2'b11, 18'd0);
    drive(3, 1'b0, 1'b1, 6'd0, 2'b11, 18'd0);
    checkData("R12 read before deselect", valOf(6'd40));
    drive(0, 1'b0, 1'b1, 6'd0, 2'b11, 18'd0);
    checkOff("R12 deselect cycle");
    idle(18'd0);
    checkOff("R12 advance after deselect");
  endtask

  task automatic t_oe;
    flowThru = 1'b0;
    drive(0, 1'b0, 1'b0, 6'd40, 2'b11, 18'd0);
    idle(18'd0);
    checkData("R13 before oe", valOf(6'd40));
    #2 oeN = 1'b1;
    #2;
    checkOff("R13 oe high");
    check("R13 oe high data", dataOut, 18'd0);
    oeN = 1'b0;
    #2;
    checkData("R13 oe back", valOf(6'd40));
    @(negedge clk);
    idle(18'd0);
  endtask

  task automatic finishRun;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=hung expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    prefill();
    idle(18'd0);
    t_flow_basic();
    idle(18'd0);
    t_pipe_basic();
    t_pipe_alternate();
    idle(18'd0);
    t_flow_alternate();
    idle(18'd0);
    t_burst_linear();
    idle(18'd0);
    t_burst_interleave();
    idle(18'd0);
    t_burst_write();
    idle(18'd0);
    t_lanes();
    idle(18'd0);
    t_bypass_merge();
    idle(18'd0);
    t_stall();
    t_deselect();
    idle(18'd0);
    t_oe();
    finishRun();
  end

endmodule